// File: doc/BRIEF.md
# Tagged Free-List Frame Allocator

This block hands out and takes back fixed-size memory frames. Each size class has its own singly linked free list. The head of every list sits in a table at `TABLE_BASE + index` in a word-addressed memory. The low two bits of a head word form a tag:

- 00: the word is a frame pointer.
- 01: the list is empty.
- 10 or 11: the request moves to another size class. The new index is the head word shifted right by two bits.

A single allocation may therefore follow a chain of redirections before it pops a frame.

A client raises `reqValid` while `reqReady` is high. For an allocation it gives a size index. For a release it gives a frame address, and the block finds the frame's class in the word just below the frame. The block reaches memory through a simple synchronous port. Read data returns on the cycle after the read strobe. Each request ends with a one-cycle `done` pulse, and the result fields are valid during that pulse.

Top module: `frameAlloc`

## Requirements
- R1: After reset `reqReady` is 1, and `done`, `memRd` and `memWr` are 0.
- R2: The first memory access of an allocation for index i is a read of address `TABLE_BASE + i`.
- R3: When the head word has tag 00 and is nonzero, the allocation returns that word as `respAddr` with no error flag. The word stored at that frame's first location is then written into the table entry of the index where the pop happened.
- R4: When the head word has tag 01, the allocation reports `respFail`. `failParam` is the originally requested index shifted left by one bit. No memory write occurs.
- R5: When the head word has tag 10 or 11, the lookup restarts at the index `head >> 2`. The entry that redirected is not rewritten.
- R6: A release reads the index at frame address minus 1. It then writes the old list head into the frame's first word, and after that writes the frame address into the table entry. `respAddr` equals the released frame address.
- R7: Up to 16 redirections are followed. A 17th redirection ends the request with `respHopErr` and no memory write.
- R8: A tag-00 head word of zero ends the request with `respNullErr` and no memory write.
- R9: Only one request is in flight. `reqReady` is 0 from acceptance through the `done` cycle, a `reqValid` that arrives while busy is ignored, and `done` lasts exactly one cycle.
- R10: `memRd` and `memWr` are never high together. Every write directly follows a read or a write of the same request.
- R11: At most one of `respFail`, `respHopErr` and `respNullErr` is set with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request will be taken |
| reqFree | input | 1 | 1 = release, 0 = allocate |
| reqIndex | input | IDX_W | Size index for allocate |
| reqAddr | input | ADDR_W | Frame address for release |
| done | output | 1 | One-cycle completion pulse |
| respAddr | output | ADDR_W | Allocated or released frame address |
| respFail | output | 1 | List empty |
| failParam | output | IDX_W+1 | Requested index shifted left by one |
| respHopErr | output | 1 | Redirection limit exceeded |
| respNullErr | output | 1 | Zero frame pointer popped |
| memAddr | output | ADDR_W | Memory word address |
| memRd | output | 1 | Read strobe, data on next cycle |
| memWr | output | 1 | Write strobe |
| memWdata | output | ADDR_W | Write data |
| memRdata | input | ADDR_W | Read data |

## Verification
A wrong index or table address inside the block shows up within the same request. Either the wrong frame is returned at the `done` pulse, or the table entry ends up holding a link that belongs to a different frame. The bench checks the externally modelled table right after each `done`, so a bad update is caught before the next request starts.

A lost redirection or an off-by-one in the hop count changes which flag appears. It also changes whether a chain of exactly sixteen hops succeeds, and that shows at the end of that one request. A state machine that takes a request while busy would produce an extra `done` or an extra memory write, and that would be seen within a few cycles.

// File: rtl/frameAllocPkg.sv
package frameAllocPkg;
  typedef enum logic [1:0] {
    ADR_TABLE = 2'd0,
    ADR_FRAME = 2'd1,
    ADR_BELOW = 2'd2
  } addrSel_e;

  typedef enum logic {
    WD_RDATA = 1'b0,
    WD_FRAME = 1'b1
  } wdSel_e;

  typedef struct packed {
    logic     memRd;
    logic     memWr;
    addrSel_e addrSel;
    wdSel_e   wdSel;
    logic     ldReq;
    logic     hop;
    logic     ldFrame;
    logic     ldIdxMem;
    logic     rspOk;
    logic     rspFail;
    logic     rspHop;
    logic     rspNull;
  } ctlStrobe_t;
endpackage

// File: rtl/frameAllocPath.sv
module frameAllocPath
  import frameAllocPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 16'h0100,
  parameter int MAX_HOPS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] memWdata,
  output logic [1:0]        headTag,
  output logic              headZero,
  output logic              hopsUsed,
  output logic [ADDR_W-1:0] respAddr,
  output logic              respFail,
  output logic [IDX_W:0]    failParam,
  output logic              respHopErr,
  output logic              respNullErr
);
  localparam int HOP_W = $clog2(MAX_HOPS + 1);

  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  origIdx;
  logic [ADDR_W-1:0] frameReg;
  logic [HOP_W-1:0]  hopCnt;
  logic [ADDR_W-1:0] tableAddr;

  assign tableAddr = TABLE_BASE + ADDR_W'(curIdx);
  assign headTag   = memRdata[1:0];
  assign headZero  = (memRdata == '0);
  assign hopsUsed  = (hopCnt == HOP_W'(MAX_HOPS));

  always_comb begin
    case (ctl.addrSel)
      ADR_FRAME: memAddr = frameReg;
      ADR_BELOW: memAddr = frameReg - ADDR_W'(1);
      default:   memAddr = tableAddr;
    endcase
    memWdata = (ctl.wdSel == WD_FRAME) ? frameReg : memRdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIdx   <= '0;
      origIdx  <= '0;
      frameReg <= '0;
      hopCnt   <= '0;
    end else begin
      if (ctl.ldReq) begin
        curIdx   <= reqIndex;
        origIdx  <= reqIndex;
        frameReg <= reqAddr;
        hopCnt   <= '0;
      end
      if (ctl.hop) begin
        curIdx <= memRdata[IDX_W+1:2];
        hopCnt <= hopCnt + HOP_W'(1);
      end
      if (ctl.ldFrame)  frameReg <= memRdata;
      if (ctl.ldIdxMem) curIdx   <= memRdata[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respAddr    <= '0;
      respFail    <= 1'b0;
      failParam   <= '0;
      respHopErr  <= 1'b0;
      respNullErr <= 1'b0;
    end else if (ctl.rspOk | ctl.rspFail | ctl.rspHop | ctl.rspNull) begin
      respAddr    <= ctl.rspOk ? frameReg : '0;
      respFail    <= ctl.rspFail;
      failParam   <= ctl.rspFail ? {origIdx, 1'b0} : '0;
      respHopErr  <= ctl.rspHop;
      respNullErr <= ctl.rspNull;
    end
  end
endmodule

// File: rtl/frameAllocCtl.sv
module frameAllocCtl
  import frameAllocPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqFree,
  input  logic [1:0] headTag,
  input  logic       headZero,
  input  logic       hopsUsed,
  output logic       reqReady,
  output logic       done,
  output ctlStrobe_t ctl
);
  typedef enum logic [3:0] {
    S_IDLE, S_A_HEAD_RD, S_A_HEAD_WT, S_A_NEXT_RD, S_A_NEXT_WT,
    S_F_IDX_RD, S_F_IDX_WT, S_F_HEAD_RD, S_F_HEAD_WT, S_F_LINK, S_RESP
  } state_e;

  state_e state, nextState;

  assign reqReady = (state == S_IDLE);
  assign done     = (state == S_RESP);

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (reqValid) begin
        ctl.ldReq = 1'b1;
        nextState = reqFree ? S_F_IDX_RD : S_A_HEAD_RD;
      end
      S_A_HEAD_RD: begin
        ctl.memRd   = 1'b1;
        ctl.addrSel = ADR_TABLE;
        nextState   = S_A_HEAD_WT;
      end
      S_A_HEAD_WT: begin
        if (headTag == 2'b00) begin
          if (headZero) begin
            ctl.rspNull = 1'b1;
            nextState   = S_RESP;
          end else begin
            ctl.ldFrame = 1'b1;
            nextState   = S_A_NEXT_RD;
          end
        end else if (headTag == 2'b01) begin
          ctl.rspFail = 1'b1;
          nextState   = S_RESP;
        end else if (hopsUsed) begin
          ctl.rspHop = 1'b1;
          nextState  = S_RESP;
        end else begin
          ctl.hop   = 1'b1;
          nextState = S_A_HEAD_RD;
        end
      end
      S_A_NEXT_RD: begin
        ctl.memRd   = 1'b1;
        ctl.addrSel = ADR_FRAME;
        nextState   = S_A_NEXT_WT;
      end
      S_A_NEXT_WT: begin
        ctl.memWr   = 1'b1;
        ctl.addrSel = ADR_TABLE;
        ctl.wdSel   = WD_RDATA;
        ctl.rspOk   = 1'b1;
        nextState   = S_RESP;
      end
      S_F_IDX_RD: begin
        ctl.memRd   = 1'b1;
        ctl.addrSel = ADR_BELOW;
        nextState   = S_F_IDX_WT;
      end
      S_F_IDX_WT: begin
        ctl.ldIdxMem = 1'b1;
        nextState    = S_F_HEAD_RD;
      end
      S_F_HEAD_RD: begin
        ctl.memRd   = 1'b1;
        ctl.addrSel = ADR_TABLE;
        nextState   = S_F_HEAD_WT;
      end
      S_F_HEAD_WT: begin
        ctl.memWr   = 1'b1;
        ctl.addrSel = ADR_FRAME;
        ctl.wdSel   = WD_RDATA;
        nextState   = S_F_LINK;
      end
      S_F_LINK: begin
        ctl.memWr   = 1'b1;
        ctl.addrSel = ADR_TABLE;
        ctl.wdSel   = WD_FRAME;
        ctl.rspOk   = 1'b1;
        nextState   = S_RESP;
      end
      S_RESP:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/frameAlloc.sv
module frameAlloc
  import frameAllocPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W = 8,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 16'h0100,
  parameter int MAX_HOPS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqFree,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              done,
  output logic [ADDR_W-1:0] respAddr,
  output logic              respFail,
  output logic [IDX_W:0]    failParam,
  output logic              respHopErr,
  output logic              respNullErr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] memWdata,
  input  logic [ADDR_W-1:0] memRdata
);
  ctlStrobe_t ctl;
  logic [1:0] headTag;
  logic       headZero;
  logic       hopsUsed;

  assign memRd = ctl.memRd;
  assign memWr = ctl.memWr;

  frameAllocCtl uCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFree(reqFree),
    .headTag(headTag), .headZero(headZero), .hopsUsed(hopsUsed),
    .reqReady(reqReady), .done(done), .ctl(ctl)
  );

  frameAllocPath #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .TABLE_BASE(TABLE_BASE), .MAX_HOPS(MAX_HOPS)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqIndex(reqIndex), .reqAddr(reqAddr),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .headTag(headTag), .headZero(headZero), .hopsUsed(hopsUsed),
    .respAddr(respAddr), .respFail(respFail), .failParam(failParam),
    .respHopErr(respHopErr), .respNullErr(respNullErr)
  );
endmodule

// File: rtl/frameAllocChk.sv
module frameAllocChk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic done,
  input logic respFail,
  input logic respHopErr,
  input logic respNullErr,
  input logic memRd,
  input logic memWr
);
  // R10: a single strobe per cycle
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(memRd && memWr));

  // R10: a write always follows a read or a write of the same request
  a_r10_write_follows: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> ($past(memRd) || $past(memWr)));

  // R9: done is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: busy from acceptance onwards
  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R9: not ready while completing
  a_r9_no_ready_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !reqReady);

  // R11: at most one outcome flag
  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $onehot0({respFail, respHopErr, respNullErr}));

  // R4, R7, R8: no write in the cycle an error result is presented
  a_r4_no_write_at_fail: assert property (@(posedge clk) disable iff (!rstN)
    (done && (respFail || respHopErr || respNullErr)) |-> !$past(memWr));
endmodule

bind frameAlloc frameAllocChk uChk (.*);

// File: tb/frameAlloc_test.sv
module frameAlloc_test;
  localparam int ADDR_W = 16;
  localparam int IDX_W = 8;
  localparam logic [15:0] TB = 16'h0100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqFree = 1'b0;
  logic [IDX_W-1:0] reqIndex = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic reqReady, done, respFail, respHopErr, respNullErr, memRd, memWr;
  logic [ADDR_W-1:0] respAddr, memAddr, memWdata;
  logic [ADDR_W-1:0] memRdata = '0;
  logic [IDX_W:0] failParam;

  always #5 clk = ~clk;

  frameAlloc uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqFree(reqFree), .reqIndex(reqIndex), .reqAddr(reqAddr), .done(done),
    .respAddr(respAddr), .respFail(respFail), .failParam(failParam),
    .respHopErr(respHopErr), .respNullErr(respNullErr), .memAddr(memAddr),
    .memRd(memRd), .memWr(memWr), .memWdata(memWdata), .memRdata(memRdata)
  );

  logic [15:0] mem [0:1023];
  always @(posedge clk) begin
    if (memRd) memRdata <= mem[memAddr[9:0]];
    if (memWr) mem[memAddr[9:0]] <= memWdata;
  end

  int compared = 0;
  int mismatched = 0;
  int doneCount = 0;
  int writeCount = 0;
  logic [15:0] firstRdAddr = '0;
  logic sawFirstRd = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct {
    string       req;
    logic [15:0] addr;
    logic        fail;
    logic        hop;
    logic        nul;
    logic [8:0]  param;
  } item_t;
  item_t expQ[$];

  // monitor: compares each completion against the queue
  always @(negedge clk) begin
    if (rstN && memRd && !sawFirstRd) begin
      firstRdAddr <= memAddr;
      sawFirstRd  <= 1'b1;
    end
    if (rstN && memWr) writeCount++;
    if (rstN && done) begin
      doneCount++;
      if (expQ.size() == 0) begin
        check("R9 unexpected done", 1, 0);
      end else begin
        item_t e;
        e = expQ.pop_front();
        check({e.req, " addr"}, respAddr, e.addr);
        check({e.req, " flags"}, {respFail, respHopErr, respNullErr},
              {e.fail, e.hop, e.nul});
        check({e.req, " param"}, failParam, e.param);
      end
    end
  end

  task automatic issue(string req, logic isFree, logic [7:0] idx, logic [15:0] addr,
                       logic [15:0] eAddr, logic eFail, logic eHop, logic eNul,
                       logic [8:0] eParam);
    item_t e;
    e.req = req; e.addr = eAddr; e.fail = eFail; e.hop = eHop; e.nul = eNul;
    e.param = eParam;
    expQ.push_back(e);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    sawFirstRd = 1'b0;
    reqValid = 1'b1; reqFree = isFree; reqIndex = idx; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
    while (expQ.size() != 0) @(negedge clk);
  endtask

  initial begin
    #2000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int w0;
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0001;
    mem[TB + 3] = 16'h0200; mem[16'h200] = 16'h0210; mem[16'h210] = 16'h0001;
    mem[16'h1FF] = 16'h0003; mem[16'h20F] = 16'h0003;
    mem[TB + 5] = 16'h000E;          // redirect (tag 10) to index 3
    mem[TB + 6] = 16'h000F;          // redirect (tag 11) to index 3
    mem[TB + 7] = 16'h0000;          // null pointer
    mem[TB + 8] = 16'h0022;          // redirect to itself
    for (int k = 0; k < 16; k++) mem[TB + 10 + k] = 16'(((10 + k + 1) << 2) | 2);
    mem[TB + 26] = 16'h0300; mem[16'h300] = 16'h0001;

    repeat (3) @(negedge clk);
    check("R1 ready", reqReady, 1);
    check("R1 done", done, 0);
    check("R1 strobes", {memRd, memWr}, 0);
    rstN = 1'b1;

    issue("R3 pop1", 0, 3, 0, 16'h0200, 0, 0, 0, 0);
    check("R2 first read", firstRdAddr, TB + 3);
    check("R3 head update", mem[TB + 3], 16'h0210);
    issue("R3 pop2", 0, 3, 0, 16'h0210, 0, 0, 0, 0);
    check("R3 head empty", mem[TB + 3], 16'h0001);

    w0 = writeCount;
    issue("R4 empty", 0, 3, 0, 0, 1, 0, 0, 9'd6);
    check("R4 no write", writeCount - w0, 0);
    check("R4 head kept", mem[TB + 3], 16'h0001);

    issue("R6 free", 1, 0, 16'h0200, 16'h0200, 0, 0, 0, 0);
    check("R6 first read", firstRdAddr, 16'h01FF);
    check("R6 link", mem[16'h200], 16'h0001);
    check("R6 head", mem[TB + 3], 16'h0200);

    issue("R5 tag10", 0, 5, 0, 16'h0200, 0, 0, 0, 0);
    check("R5 target head", mem[TB + 3], 16'h0001);
    check("R5 redirect kept", mem[TB + 5], 16'h000E);
    issue("R5 tag11 empty", 0, 6, 0, 0, 1, 0, 0, 9'd12);

    w0 = writeCount;
    issue("R8 null", 0, 7, 0, 0, 0, 0, 1, 0);
    check("R8 no write", writeCount - w0, 0);

    w0 = writeCount;
    issue("R7 cycle", 0, 8, 0, 0, 0, 1, 0, 0);
    check("R7 no write", writeCount - w0, 0);
    issue("R7 sixteen hops", 0, 10, 0, 16'h0300, 0, 0, 0, 0);
    check("R7 final head", mem[TB + 26], 16'h0001);

    // R9: a request raised while busy is ignored
    mem[TB + 4] = 16'h0220; mem[16'h220] = 16'h0001; mem[16'h21F] = 16'h0004;
    w0 = doneCount;
    begin
      item_t e;
      e.req = "R9 busy alloc"; e.addr = 16'h0220; e.fail = 0; e.hop = 0;
      e.nul = 0; e.param = 0;
      expQ.push_back(e);
    end
    @(negedge clk);
    reqValid = 1'b1; reqFree = 1'b0; reqIndex = 8'd4;
    @(negedge clk);
    reqFree = 1'b1; reqAddr = 16'h0220;
    check("R9 busy", reqReady, 0);
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    repeat (12) @(negedge clk);
    check("R9 single done", doneCount - w0, 1);
    check("R9 no free", mem[TB + 4], 16'h0001);
    check("R9 ready again", reqReady, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule